// File: doc/BRIEF.md
# Three-Wire Control Word Receiver

This block receives control words over a three-wire serial bus (data, bit clock, frame strobe) and keeps the working registers that set up a quadrature IF transceiver: the synthesizer main divider, the reference divider code, the charge-pump code, the test selection, the I/Q offset fields and the receive gain code. While the strobe is low, each rising edge of the bit clock shifts one data bit into a 21-bit register. When the strobe rises, the block examines the last 21 bits. A frame carries a 4-bit chip address and a subaddress bit. The subaddress bit chooses which of the two register banks is written.

The block also combines the register contents with the live pin state. Three enable pins select the operating mode. A register bit chooses whether the receive gain code comes from the register or from six external gain pins. The reference-output enable is raised only while the transmitter is on and the register allows it. All serial pins are synchronised to the system clock, and edges are detected there, so the bit clock must be slower than about a third of the system clock.

Top module: `tw_ctrl_if`

## Requirements
- R1: After a synchronous active-low reset the outputs are: n_div = 352, ref_code = 2'b10, pump_code = 3'b111, test_sel = 2'b00, s_bits = 2'b00, i_ofs = 3'b000, q_ofs = 3'b000, gain_reg = 6'b111111, gain_src = 0 and vref_vc = 1.
- R2: A bit is shifted in only on a rising edge of ser_clk seen while ser_stb is low. A rising edge of ser_stb examines the last 21 bits shifted. In that window, bit position j = 0 is the earliest bit and j = 20 is the latest.
- R3: A frame is applied only if j0..j3 equal 1,1,1,0. Otherwise no register changes. j4 is the subaddress: 0 selects bank 0 and 1 selects bank 1.
- R4: Bank 0 decodes as follows:
  - n_div comes from j5..j13, with j5 as its MSB.
  - ref_code = {j14, j15}.
  - pump_code = {j18, j17, j16}, so j16 is the LSB.
  - test_sel = {j20, j19}.
- R5: Bank 1 decodes as follows:
  - s_bits = {j5, j6}.
  - i_ofs = {j7, j8, j9}.
  - q_ofs = {j10, j11, j12}.
  - gain_reg bit k = j(13+k) for k = 0..5.
  - gain_src = j19.
  - vref_vc = j20.
- R6: When fewer than 21 bits have been shifted since the previous strobe rise, a strobe rise changes no register. A bit-clock rise that is seen in the same cycle as the strobe rise is not shifted.
- R7: A bank-0 frame whose divider field is below 64 leaves n_div unchanged. The other bank-0 fields are still written.
- R8: rx_gain equals gain_pins while gain_src = 0, and equals gain_reg while gain_src = 1. Code 0 means maximum gain.
- R9: op_mode is set by the enable pins, where each pin code is written as {pll_en, rx_en, tx_en}:

  | Pins | Mode | op_mode |
  |------|------|---------|
  | pll_en = 0 (any rx_en, tx_en) | sleep | 0 |
  | 101 | transmit, receiver standby | 1 |
  | 111 | wait | 2 |
  | 110 | receive | 3 |
  | 100 | transmit, receiver off | 4 |

- R10: vref_en is 1 exactly when vref_vc = 1 and op_mode is 1 or 4.
- R11: The mode pins never alter the registers. Frames sent while op_mode = 0 are applied like any other frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial data |
| ser_clk | input | 1 | Serial bit clock |
| ser_stb | input | 1 | Frame strobe; low frames a word, rising edge loads |
| pll_en | input | 1 | Synthesizer enable pin |
| rx_en | input | 1 | Receive enable pin |
| tx_en | input | 1 | Transmit enable pin |
| gain_pins | input | 6 | External receive gain code |
| n_div | output | 9 | Main divider ratio |
| ref_code | output | 2 | Reference divider code |
| pump_code | output | 3 | Charge-pump current code |
| test_sel | output | 2 | Test selection {x1,x0} |
| s_bits | output | 2 | Spare mode bits |
| i_ofs | output | 3 | I offset field |
| q_ofs | output | 3 | Q offset field |
| gain_reg | output | 6 | Register gain code |
| gain_src | output | 1 | 1 selects register gain code |
| vref_vc | output | 1 | Reference enable bit |
| op_mode | output | 3 | Decoded operating mode |
| rx_gain | output | 6 | Effective receive gain code |
| vref_en | output | 1 | Reference output enable |

## Verification
The strobe rise and a bit-clock rise can be seen in the same system cycle. In that case the frame is closed and the bit is dropped, not shifted. The bench provokes this by sending 20 bits normally and then raising the bit clock and the strobe in the same instant. Because both pins pass through matching synchronisers, the block sees both events in one cycle. The bench expects no register to change, because only 20 bits were counted. A following normal frame must then apply, which shows that the aborted frame left the counter cleared.

// File: rtl/tw_ctrl_pkg.sv
// Package: shared widths, frame layout constants and the operating-mode type
// for the three-wire control word receiver.
package tw_ctrl_pkg;
    localparam int WORD_BITS = 21;
    localparam int ADDR_BITS = 4;
    localparam logic [ADDR_BITS-1:0] CHIP_ADDR = 4'b1110;
    localparam int N_BITS    = 9;
    localparam int GAIN_BITS = 6;
    localparam int N_MIN     = 64;

    typedef enum logic [2:0] {
        MODE_SLEEP   = 3'd0,
        MODE_TX_STBY = 3'd1,
        MODE_WAIT    = 3'd2,
        MODE_RX      = 3'd3,
        MODE_TX_ONLY = 3'd4
    } op_mode_t;
endpackage

// File: rtl/tw_sync_edge.sv
// Module: tw_sync_edge
// Brings WIDTH asynchronous pins into the clk domain through SYNC_STAGES
// flops and reports rising edges. Assumes each pin holds a level for at
// least two clk cycles.
module tw_sync_edge #(
    parameter int WIDTH       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [WIDTH-1:0] pin_idle,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_pin
            logic [SYNC_STAGES:0] chain;
            // shift the pin through the synchroniser plus one history stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {(SYNC_STAGES+1){pin_idle[g]}};
                else        chain <= {chain[SYNC_STAGES-1:0], pin_in[g]};
            end
            assign level[g] = chain[SYNC_STAGES-1];
            assign rise[g]  = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
        end
    endgenerate
endmodule

// File: rtl/tw_shifter.sv
// Module: tw_shifter
// Shifts serial data in (earliest bit ends at the top) on bit-clock rises
// seen while the strobe is low, and counts the bits of the current frame.
// Assumes synchronised level and edge inputs.
module tw_shifter
    import tw_ctrl_pkg::*;
#(
    parameter int NBITS = WORD_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_lvl,
    input  logic             bclk_rise,
    input  logic             stb_lvl,
    input  logic             stb_rise,
    output logic [NBITS-1:0] shreg,
    output logic             full
);
    localparam int CW = $clog2(NBITS + 1);
    logic [CW-1:0] cnt;
    logic          shift_en;

    assign shift_en = bclk_rise & ~stb_lvl;

    // shift register: take one bit per qualified bit-clock rise
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (shift_en) shreg <= {shreg[NBITS-2:0], data_lvl};
    end

    // bit counter: cleared at each frame close, saturates at a full word
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (stb_rise)                   cnt <= '0;
        else if (shift_en && !full)          cnt <= cnt + 1'b1;
    end

    assign full = (cnt == CW'(NBITS));
endmodule

// File: rtl/tw_regbank.sv
// Module: tw_regbank
// Working registers for both banks with power-up defaults. On a load
// request it checks the address, picks the bank from the subaddress and
// refuses divider values below N_MIN. Assumes shreg[NBITS-1] is the
// earliest bit of the frame.
module tw_regbank
    import tw_ctrl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [WORD_BITS-1:0] shreg,
    output logic [N_BITS-1:0]    n_div,
    output logic [1:0]           ref_code,
    output logic [2:0]           pump_code,
    output logic [1:0]           test_sel,
    output logic [1:0]           s_bits,
    output logic [2:0]           i_ofs,
    output logic [2:0]           q_ofs,
    output logic [GAIN_BITS-1:0] gain_reg,
    output logic                 gain_src,
    output logic                 vref_vc
);
    localparam int TOP   = WORD_BITS - 1;
    localparam int SA_IX = TOP - ADDR_BITS;
    localparam int PL_HI = SA_IX - 1;

    logic                 addr_ok;
    logic                 wr0;
    logic                 wr1;
    logic [N_BITS-1:0]    n_new;
    logic [GAIN_BITS-1:0] gain_new;
    logic [2:0]           pump_new;

    assign addr_ok = (shreg[TOP -: ADDR_BITS] == CHIP_ADDR);
    assign wr0     = load & addr_ok & ~shreg[SA_IX];
    assign wr1     = load & addr_ok &  shreg[SA_IX];
    assign n_new   = shreg[PL_HI -: N_BITS];

    genvar k;
    generate
        // gain bits arrive LSB first: b0 directly after the offset fields
        for (k = 0; k < GAIN_BITS; k++) begin : g_gain
            assign gain_new[k] = shreg[PL_HI - 8 - k];
        end
        // pump bits arrive LSB first
        for (k = 0; k < 3; k++) begin : g_pump
            assign pump_new[k] = shreg[PL_HI - 11 - k];
        end
    endgenerate

    // bank 0: divider, reference code, pump code, test selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_div     <= N_BITS'(352);
            ref_code  <= 2'b10;
            pump_code <= 3'b111;
            test_sel  <= 2'b00;
        end else if (wr0) begin
            if (n_new >= N_BITS'(N_MIN)) n_div <= n_new;
            ref_code  <= shreg[PL_HI-9 -: 2];
            pump_code <= pump_new;
            test_sel  <= {shreg[0], shreg[1]};
        end
    end

    // bank 1: spare bits, offsets, gain code, gain source, reference enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_bits   <= 2'b00;
            i_ofs    <= 3'b000;
            q_ofs    <= 3'b000;
            gain_reg <= '1;
            gain_src <= 1'b0;
            vref_vc  <= 1'b1;
        end else if (wr1) begin
            s_bits   <= shreg[PL_HI -: 2];
            i_ofs    <= shreg[PL_HI-2 -: 3];
            q_ofs    <= shreg[PL_HI-5 -: 3];
            gain_reg <= gain_new;
            gain_src <= shreg[1];
            vref_vc  <= shreg[0];
        end
    end
endmodule

// File: rtl/tw_mode_decode.sv
// Module: tw_mode_decode
// Combinational: decodes the enable pins into an operating mode, selects the
// effective gain code and forms the reference-output enable. Assumes the
// pins are already stable in the clk domain or used only as levels.
module tw_mode_decode
    import tw_ctrl_pkg::*;
(
    input  logic                 pll_en,
    input  logic                 rx_en,
    input  logic                 tx_en,
    input  logic [GAIN_BITS-1:0] gain_pins,
    input  logic [GAIN_BITS-1:0] gain_reg,
    input  logic                 gain_src,
    input  logic                 vref_vc,
    output op_mode_t             op_mode,
    output logic [GAIN_BITS-1:0] rx_gain,
    output logic                 vref_en
);
    // pin combination to mode
    always_comb begin
        if (!pll_en)                op_mode = MODE_SLEEP;
        else if (!rx_en &&  tx_en)  op_mode = MODE_TX_STBY;
        else if ( rx_en &&  tx_en)  op_mode = MODE_WAIT;
        else if ( rx_en && !tx_en)  op_mode = MODE_RX;
        else                        op_mode = MODE_TX_ONLY;
    end

    // gain source and reference enable
    always_comb begin
        rx_gain = gain_src ? gain_reg : gain_pins;
        vref_en = vref_vc &&
                  (op_mode == MODE_TX_STBY || op_mode == MODE_TX_ONLY);
    end
endmodule

// File: rtl/tw_ctrl_if.sv
// Module: tw_ctrl_if (top)
// Three-wire control word receiver: synchronises the bus, shifts frames,
// loads the working registers on the strobe rise and decodes the mode pins.
// Assumes the bit clock runs well below a third of clk.
module tw_ctrl_if
    import tw_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_data,
    input  logic       ser_clk,
    input  logic       ser_stb,
    input  logic       pll_en,
    input  logic       rx_en,
    input  logic       tx_en,
    input  logic [5:0] gain_pins,
    output logic [8:0] n_div,
    output logic [1:0] ref_code,
    output logic [2:0] pump_code,
    output logic [1:0] test_sel,
    output logic [1:0] s_bits,
    output logic [2:0] i_ofs,
    output logic [2:0] q_ofs,
    output logic [5:0] gain_reg,
    output logic       gain_src,
    output logic       vref_vc,
    output logic [2:0] op_mode,
    output logic [5:0] rx_gain,
    output logic       vref_en
);
    logic [2:0]           lvl;
    logic [2:0]           rise;
    logic [WORD_BITS-1:0] shreg;
    logic                 full;
    logic                 stb_rise;
    logic                 load;
    op_mode_t             mode_q;

    tw_sync_edge #(.WIDTH(3), .SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   ({ser_stb, ser_clk, ser_data}),
        .pin_idle (3'b100),
        .level    (lvl),
        .rise     (rise)
    );

    assign stb_rise = rise[2];
    assign load     = stb_rise & full;

    tw_shifter #(.NBITS(WORD_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_lvl  (lvl[0]),
        .bclk_rise (rise[1]),
        .stb_lvl   (lvl[2]),
        .stb_rise  (stb_rise),
        .shreg     (shreg),
        .full      (full)
    );

    tw_regbank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .shreg     (shreg),
        .n_div     (n_div),
        .ref_code  (ref_code),
        .pump_code (pump_code),
        .test_sel  (test_sel),
        .s_bits    (s_bits),
        .i_ofs     (i_ofs),
        .q_ofs     (q_ofs),
        .gain_reg  (gain_reg),
        .gain_src  (gain_src),
        .vref_vc   (vref_vc)
    );

    tw_mode_decode u_mode (
        .pll_en    (pll_en),
        .rx_en     (rx_en),
        .tx_en     (tx_en),
        .gain_pins (gain_pins),
        .gain_reg  (gain_reg),
        .gain_src  (gain_src),
        .vref_vc   (vref_vc),
        .op_mode   (mode_q),
        .rx_gain   (rx_gain),
        .vref_en   (vref_en)
    );

    assign op_mode = mode_q;
endmodule

// File: rtl/tw_ctrl_if_chk.sv
// Module: tw_ctrl_if_chk
// Property checker bound to tw_ctrl_if; observes ports and the strobe edge.
module tw_ctrl_if_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stb_rise,
    input logic       pll_en,
    input logic [5:0] gain_pins,
    input logic [8:0] n_div,
    input logic [1:0] ref_code,
    input logic [2:0] pump_code,
    input logic [1:0] test_sel,
    input logic [1:0] s_bits,
    input logic [2:0] i_ofs,
    input logic [2:0] q_ofs,
    input logic [5:0] gain_reg,
    input logic       gain_src,
    input logic       vref_vc,
    input logic [2:0] op_mode,
    input logic [5:0] rx_gain,
    input logic       vref_en
);
    // R6
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_rise |=> $stable({n_div, ref_code, pump_code, test_sel, s_bits,
                               i_ofs, q_ofs, gain_reg, gain_src, vref_vc}));
    // R7
    n_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        n_div >= 9'd64);
    // R8
    pin_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gain_src |-> rx_gain == gain_pins);
    // R8
    reg_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_src |-> rx_gain == gain_reg);
    // R9
    sleep_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |-> op_mode == 3'd0);
    // R10
    vref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vref_en |-> vref_vc && (op_mode == 3'd1 || op_mode == 3'd4));
endmodule

bind tw_ctrl_if tw_ctrl_if_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_rise  (stb_rise),
    .pll_en    (pll_en),
    .gain_pins (gain_pins),
    .n_div     (n_div),
    .ref_code  (ref_code),
    .pump_code (pump_code),
    .test_sel  (test_sel),
    .s_bits    (s_bits),
    .i_ofs     (i_ofs),
    .q_ofs     (q_ofs),
    .gain_reg  (gain_reg),
    .gain_src  (gain_src),
    .vref_vc   (vref_vc),
    .op_mode   (op_mode),
    .rx_gain   (rx_gain),
    .vref_en   (vref_en)
);

// File: tb/sim_tw_ctrl_if.sv
module sim_tw_ctrl_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_stb = 1'b1;
    logic pll_en = 1'b0, rx_en = 1'b0, tx_en = 1'b0;
    logic [5:0] gain_pins = 6'd0;
    logic [8:0] n_div;
    logic [1:0] ref_code, test_sel, s_bits;
    logic [2:0] pump_code, i_ofs, q_ofs, op_mode;
    logic [5:0] gain_reg, rx_gain;
    logic gain_src, vref_vc, vref_en;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // expected register model
    logic [8:0] e_n; logic [1:0] e_ref, e_tst, e_s; logic [2:0] e_pmp, e_i, e_q;
    logic [5:0] e_gain; logic e_src, e_vc;

    always #10 clk = ~clk;

    tw_ctrl_if u0 (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk(req, "n_div", n_div, e_n);       chk(req, "ref_code", ref_code, e_ref);
        chk(req, "pump_code", pump_code, e_pmp); chk(req, "test_sel", test_sel, e_tst);
        chk(req, "s_bits", s_bits, e_s);     chk(req, "i_ofs", i_ofs, e_i);
        chk(req, "q_ofs", q_ofs, e_q);       chk(req, "gain_reg", gain_reg, e_gain);
        chk(req, "gain_src", gain_src, e_src); chk(req, "vref_vc", vref_vc, e_vc);
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send the last nb bits of w (w[20] is position j0), then close the frame
    task automatic send(input logic [31:0] w, input int nb, input bit clash);
        ser_stb = 1'b0; ticks(4);
        for (int b = nb - 1; b >= 0; b--) begin
            ser_data = w[b]; ticks(3);
            if (clash && b == 0) begin
                ser_clk = 1'b1; ser_stb = 1'b1; ticks(3);
            end else begin
                ser_clk = 1'b1; ticks(3);
            end
            ser_clk = 1'b0; ticks(3);
        end
        ser_stb = 1'b1; ticks(8);
    endtask

    // apply a correctly addressed full frame to the model (R3, R4, R5, R7)
    task automatic model(input logic [20:0] w);
        if (w[20:17] != 4'b1110) return;
        if (!w[16]) begin
            if (w[15:7] >= 9'd64) e_n = w[15:7];
            e_ref = {w[6], w[5]}; e_pmp = {w[2], w[3], w[4]}; e_tst = {w[0], w[1]};
        end else begin
            e_s = {w[15], w[14]}; e_i = {w[13], w[12], w[11]}; e_q = {w[10], w[9], w[8]};
            for (int k = 0; k < 6; k++) e_gain[k] = w[7 - k];
            e_src = w[1]; e_vc = w[0];
        end
    endtask

    function automatic int exp_mode(input logic p, input logic r, input logic t);
        if (!p) return 0;
        if (!r && t) return 1;
        if (r && t) return 2;
        if (r && !t) return 3;
        return 4;
    endfunction

    task automatic chk_pins(input string req);
        int m;
        ticks(1);
        m = exp_mode(pll_en, rx_en, tx_en);
        chk(req, "op_mode", op_mode, m);
        chk(req, "rx_gain", rx_gain, e_src ? e_gain : gain_pins);
        chk(req, "vref_en", vref_en, (e_vc && (m == 1 || m == 4)) ? 1 : 0);
    endtask

    initial begin
        ticks(150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [20:0] w;
        void'($urandom(32'd1729));
        e_n = 9'd352; e_ref = 2'b10; e_pmp = 3'b111; e_tst = 2'b00; e_s = 2'b00;
        e_i = 3'b000; e_q = 3'b000; e_gain = 6'h3f; e_src = 1'b0; e_vc = 1'b1;
        ticks(5); rst_n = 1'b1; ticks(3);
        chk_regs("R1");
        gain_pins = 6'd9; pll_en = 1'b1; tx_en = 1'b1; chk_pins("R10");

        // R4: directed bank-0 frame; N=100, ref 01, pump 3'b011 (c0=1,c1=1,c2=0), test {x1,x0}=2'b10
        w = {4'b1110, 1'b0, 9'd100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
        send(w, 21, 0); model(w); chk_regs("R4");
        // R7: N below 64 kept, other fields written
        w = {4'b1110, 1'b0, 9'd63, 2'b11, 3'b000, 2'b11};
        send(w, 21, 0); model(w); chk_regs("R7"); chk("R7", "n kept", n_div, 100);
        // R5: bank-1 frame selecting register gain
        w = {4'b1110, 1'b1, 2'b10, 3'b101, 3'b011, 6'b100000, 1'b1, 1'b0};
        send(w, 21, 0); model(w); chk_regs("R5"); chk("R5", "gain b0", gain_reg, 1);
        chk_pins("R8");
        // R3: wrong address
        w = {4'b0110, 1'b1, 16'hFFFF};
        send(w, 21, 0); chk_regs("R3");
        // R6: short frame
        w = {4'b1110, 1'b0, 9'd200, 7'h7f};
        send(w, 20, 0); chk_regs("R6");
        // R6: strobe rise in the same cycle as the 21st bit-clock rise
        send(w, 21, 1); chk_regs("R6 clash");
        send(w, 21, 0); model(w); chk_regs("R6 after clash");
        // R2: extra leading bits, last 21 count
        send({11'h5a5, w}, 32, 0); model(w); chk_regs("R2");

        // R11: programming in sleep mode
        pll_en = 1'b0; rx_en = 1'b1; tx_en = 1'b1;
        w = {4'b1110, 1'b1, 2'b01, 3'b110, 3'b001, 6'b010101, 1'b0, 1'b1};
        send(w, 21, 0); model(w); chk_regs("R11"); chk_pins("R9");

        // random frames and pins
        for (int it = 0; it < 50; it++) begin
            int nb; logic [31:0] pre;
            w = 21'($urandom);
            if ($urandom_range(0, 9) < 8) w[20:17] = 4'b1110;
            nb = 21 + $urandom_range(0, 4);
            pre = $urandom;
            if ($urandom_range(0, 7) == 0) begin
                nb = $urandom_range(5, 20);
                send({11'd0, w}, nb, 0);
            end else begin
                send((pre << 21) | {11'd0, w}, nb, 0);
                model(w);
            end
            chk_regs("R2 R3 R4 R5 R7 random");
            {pll_en, rx_en, tx_en} = 3'($urandom);
            gain_pins = 6'($urandom);
            chk_pins("R8 R9 R10 random");
            for (int k = 0; k < 8; k++) begin
                {pll_en, rx_en, tx_en} = 3'(k);
                chk_pins("R9 R10 R11 sweep");
            end
            chk_regs("R11 pins");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule